// File: doc/BRIEF.md
# ADC Code-Density Linearity Analyzer

This block sits behind an 8-bit analog-to-digital converter under test. The converter is fed a sine wave that slightly overdrives its full-scale range. After a start pulse, the block counts how often each output code appears over a record whose length is a power of two. When the record is full, it walks the inner codes in ascending order. For each code it fetches the count that an ideal converter would produce, divides the measured count by that expected count, and subtracts one to get the differential nonlinearity (DNL) in LSBs. It then sums the DNL values into integral nonlinearity (INL).

The block keeps only the extreme values: the largest and smallest DNL and the largest and smallest INL. It also reports the raw counts of the two saturated end codes, which a separate stage uses to fit the offset and amplitude of the sine wave. Expected counts come from outside through a simple request port with a fixed one-cycle answer latency. A one-cycle done pulse marks the end of the analysis.

Top module: `hist_adc_analyzer`

## Requirements
- R1: After reset, `done`, `ref_req` and `ref_zero` are low, and all four peak outputs and both end-code counts read zero.
- R2: While acquisition is active, each cycle with `code_valid` high adds one to the bin selected by `code`. A cycle with `code_valid` low changes no bin, whatever value `code` carries.
- R3: Acquisition stops after exactly 2^RECORD_LOG2 accepted samples. Samples offered after that point are not counted.
- R4: `h_low` shows the count of code 0 and `h_high` shows the count of code 2^CODE_W-1.
- R5: During analysis, `ref_req` is high for single cycles with `ref_idx` stepping from 1 to 2^CODE_W-2 in ascending order, one request per code. The end codes are never requested. `ref_cnt` is sampled one cycle after each request.
- R6: The DNL of code i, as signed fixed point with FRAC_W fractional bits, equals floor(H(i)·2^FRAC_W / ref(i)) − 2^FRAC_W.
- R7: The INL of code i is the sum of the DNL values of codes 1 through i.
- R8: `dnl_max`/`dnl_min` and `inl_max`/`inl_min` are the largest and smallest values over codes 1 to 2^CODE_W-2. The first evaluated code loads both registers of each pair.
- R9: A reference count of zero makes that code's DNL exactly zero and sets `ref_zero`. The flag stays set until the next start.
- R10: `done` is high for exactly one cycle after the last inner code is evaluated. The peak outputs then hold their values until the next start.
- R11: `start` clears the histogram, the peaks and the error flag, and restarts acquisition, including when a run is already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear and begin a new record |
| code_valid | input | 1 | Qualifies `code` |
| code | input | CODE_W | Converter output code |
| ref_req | output | 1 | Request for an expected count |
| ref_idx | output | CODE_W | Code whose expected count is requested |
| ref_cnt | input | CNT_W | Expected count, valid the cycle after `ref_req` |
| done | output | 1 | One-cycle end-of-analysis pulse |
| ref_zero | output | 1 | Sticky flag: a zero expected count was seen |
| h_low | output | CNT_W | Count of the lowest code |
| h_high | output | CNT_W | Count of the highest code |
| dnl_max | output | CNT_W+FRAC_W+2 | Largest DNL, signed |
| dnl_min | output | CNT_W+FRAC_W+2 | Smallest DNL, signed |
| inl_max | output | CNT_W+FRAC_W+2+CODE_W | Largest INL, signed |
| inl_min | output | CNT_W+FRAC_W+2+CODE_W | Smallest INL, signed |

## Verification
A bin changes one edge after a sample is accepted. The end of the record is seen one edge after the final sample. Each request is followed by a response register in the bench, and the design samples it on the next edge. A code then takes a request cycle, a load cycle, CNT_W+FRAC_W divider steps plus one finish cycle, and an accumulate cycle. This length varies with the parameters, so the bench does not predict the cycle of `done`: it polls `done` on falling edges, checks every result in that same cycle, checks one cycle later that `done` has fallen, and checks again several cycles later that nothing has moved.

// File: rtl/hist_pkg.sv
package hist_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACQ,
      ST_REQ,
      ST_LOAD,
      ST_DIV,
      ST_ACC
   } ana_state_t;
endpackage

// File: rtl/hist_div.sv
module hist_div #(
   parameter int NUM_W = 24,
   parameter int DEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             fin,
   output logic [NUM_W-1:0] quo
);
   localparam int CW = $clog2(NUM_W + 1);

   logic [DEN_W-1:0] rem_q;
   logic [DEN_W-1:0] den_q;
   logic [NUM_W-1:0] sh_q;
   logic [CW-1:0]    cnt_q;
   logic             run_q;
   logic             fin_q;
   logic [DEN_W:0]   shifted;
   logic             take;

   assign shifted = {rem_q, sh_q[NUM_W-1]};
   assign take    = shifted >= {1'b0, den_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         den_q <= '0;
         sh_q  <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (go) begin
            rem_q <= '0;
            den_q <= den;
            sh_q  <= num;
            cnt_q <= CW'(NUM_W);
            run_q <= 1'b1;
         end else if (run_q) begin
            if (take) begin
               rem_q <= DEN_W'(shifted - {1'b0, den_q});
               sh_q  <= {sh_q[NUM_W-2:0], 1'b1};
            end else begin
               rem_q <= DEN_W'(shifted);
               sh_q  <= {sh_q[NUM_W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end
         end
      end
   end

   assign fin = fin_q;
   assign quo = sh_q;
endmodule

// File: rtl/hist_bins.sv
module hist_bins #(
   parameter int CODE_W      = 8,
   parameter int CNT_W       = 16,
   parameter int RECORD_LOG2 = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              valid,
   input  logic [CODE_W-1:0] code,
   input  logic [CODE_W-1:0] rd_idx,
   output logic [CNT_W-1:0]  rd_cnt,
   output logic [CNT_W-1:0]  lo_cnt,
   output logic [CNT_W-1:0]  hi_cnt,
   output logic              acq_done
);
   localparam int NBINS = 2 ** CODE_W;
   localparam logic [CNT_W-1:0]       BIN_ONE = CNT_W'(1);
   localparam logic [RECORD_LOG2-1:0] N_ONE   = RECORD_LOG2'(1);
   localparam logic [RECORD_LOG2-1:0] N_LAST  = '1;

   logic [CNT_W-1:0]       bin_q [NBINS];
   logic [RECORD_LOG2-1:0] n_q;
   logic                   acq_q;
   logic                   done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NBINS; b++) bin_q[b] <= '0;
         n_q    <= '0;
         acq_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (clr) begin
            for (int b = 0; b < NBINS; b++) bin_q[b] <= '0;
            n_q   <= '0;
            acq_q <= 1'b1;
         end else if (acq_q && valid) begin
            bin_q[code] <= bin_q[code] + BIN_ONE;
            n_q         <= n_q + N_ONE;
            if (n_q == N_LAST) begin
               acq_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign rd_cnt   = bin_q[rd_idx];
   assign lo_cnt   = bin_q[0];
   assign hi_cnt   = bin_q[NBINS-1];
   assign acq_done = done_q;
endmodule

// File: rtl/hist_peak.sv
module hist_peak #(
   parameter int W = 26
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                upd,
   input  logic                first,
   input  logic signed [W-1:0] val,
   output logic signed [W-1:0] hi,
   output logic signed [W-1:0] lo
);
   logic signed [W-1:0] hi_q;
   logic signed [W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (clr) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (upd) begin
         if (first || val > hi_q) hi_q <= val;
         if (first || val < lo_q) lo_q <= val;
      end
   end

   assign hi = hi_q;
   assign lo = lo_q;
endmodule

// File: rtl/hist_adc_analyzer.sv
module hist_adc_analyzer
   import hist_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter int CNT_W       = 16,
   parameter int RECORD_LOG2 = 15,
   parameter int FRAC_W      = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   start,
   input  logic                                   code_valid,
   input  logic [CODE_W-1:0]                      code,
   output logic                                   ref_req,
   output logic [CODE_W-1:0]                      ref_idx,
   input  logic [CNT_W-1:0]                       ref_cnt,
   output logic                                   done,
   output logic                                   ref_zero,
   output logic [CNT_W-1:0]                       h_low,
   output logic [CNT_W-1:0]                       h_high,
   output logic signed [CNT_W+FRAC_W+1:0]         dnl_max,
   output logic signed [CNT_W+FRAC_W+1:0]         dnl_min,
   output logic signed [CNT_W+FRAC_W+CODE_W+1:0]  inl_max,
   output logic signed [CNT_W+FRAC_W+CODE_W+1:0]  inl_min
);
   localparam int NUM_W = CNT_W + FRAC_W;
   localparam int DNL_W = NUM_W + 2;
   localparam int INL_W = DNL_W + CODE_W;
   localparam logic [CODE_W-1:0] IDX_FIRST = CODE_W'(1);
   localparam logic [CODE_W-1:0] IDX_LAST  = {{(CODE_W-1){1'b1}}, 1'b0};
   localparam logic signed [DNL_W-1:0] DNL_UNIT = DNL_W'(1) << FRAC_W;

   if (CODE_W < 2) begin : g_bad_code
      $error("CODE_W must be at least 2");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("FRAC_W must be at least 1");
   end
   if (CNT_W < RECORD_LOG2 + 1) begin : g_bad_cnt
      $error("CNT_W too narrow to hold a full record in one bin");
   end

   ana_state_t               st_q;
   logic [CODE_W-1:0]        idx_q;
   logic signed [DNL_W-1:0]  dnl_q;
   logic signed [INL_W-1:0]  inl_q;
   logic signed [INL_W-1:0]  inl_next;
   logic                     err_q;
   logic                     done_q;
   logic [CNT_W-1:0]         h_cur;
   logic                     acq_end;
   logic                     div_go;
   logic                     div_fin;
   logic [NUM_W-1:0]         div_q;
   logic                     pk_upd;

   hist_bins #(
      .CODE_W(CODE_W), .CNT_W(CNT_W), .RECORD_LOG2(RECORD_LOG2)
   ) u_bins (
      .clk(clk), .rst_n(rst_n), .clr(start), .valid(code_valid), .code(code),
      .rd_idx(idx_q), .rd_cnt(h_cur), .lo_cnt(h_low), .hi_cnt(h_high),
      .acq_done(acq_end)
   );

   assign div_go = (st_q == ST_LOAD) && !start && (ref_cnt != '0);

   hist_div #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
      .clk(clk), .rst_n(rst_n), .go(div_go),
      .num({h_cur, {FRAC_W{1'b0}}}), .den(ref_cnt),
      .fin(div_fin), .quo(div_q)
   );

   assign inl_next = inl_q + {{CODE_W{dnl_q[DNL_W-1]}}, dnl_q};
   assign pk_upd   = (st_q == ST_ACC) && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         dnl_q  <= '0;
         inl_q  <= '0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            st_q  <= ST_ACQ;
            idx_q <= '0;
            inl_q <= '0;
            err_q <= 1'b0;
         end else begin
            case (st_q)
               ST_ACQ: if (acq_end) begin
                  st_q  <= ST_REQ;
                  idx_q <= IDX_FIRST;
               end
               ST_REQ: st_q <= ST_LOAD;
               ST_LOAD: if (ref_cnt == '0) begin
                  dnl_q <= '0;
                  err_q <= 1'b1;
                  st_q  <= ST_ACC;
               end else begin
                  st_q <= ST_DIV;
               end
               ST_DIV: if (div_fin) begin
                  dnl_q <= $signed({2'b00, div_q}) - DNL_UNIT;
                  st_q  <= ST_ACC;
               end
               ST_ACC: begin
                  inl_q <= inl_next;
                  if (idx_q == IDX_LAST) begin
                     done_q <= 1'b1;
                     st_q   <= ST_IDLE;
                  end else begin
                     idx_q <= idx_q + IDX_FIRST;
                     st_q  <= ST_REQ;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   hist_peak #(.W(DNL_W)) u_pk_dnl (
      .clk(clk), .rst_n(rst_n), .clr(start), .upd(pk_upd),
      .first(idx_q == IDX_FIRST), .val(dnl_q), .hi(dnl_max), .lo(dnl_min)
   );

   hist_peak #(.W(INL_W)) u_pk_inl (
      .clk(clk), .rst_n(rst_n), .clr(start), .upd(pk_upd),
      .first(idx_q == IDX_FIRST), .val(inl_next), .hi(inl_max), .lo(inl_min)
   );

   assign ref_req  = (st_q == ST_REQ);
   assign ref_idx  = idx_q;
   assign done     = done_q;
   assign ref_zero = err_q;
endmodule

// File: rtl/hist_adc_analyzer_chk.sv
module hist_adc_analyzer_chk #(
   parameter int CODE_W = 8,
   parameter int DNL_W  = 26,
   parameter int INL_W  = 34
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start,
   input logic                     done,
   input logic                     ref_req,
   input logic [CODE_W-1:0]        ref_idx,
   input logic                     ref_zero,
   input logic signed [DNL_W-1:0]  dnl_max,
   input logic signed [DNL_W-1:0]  dnl_min,
   input logic signed [INL_W-1:0]  inl_max,
   input logic signed [INL_W-1:0]  inl_min
);
   localparam logic [CODE_W-1:0] TOP_CODE = '1;

   logic held_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     held_q <= 1'b0;
      else if (start) held_q <= 1'b0;
      else if (done)  held_q <= 1'b1;
   end

   a_r5_inner_only: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |-> (ref_idx != '0) && (ref_idx != TOP_CODE));

   a_r5_single_req: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |=> !ref_req);

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && !start) |=> $stable(dnl_max) && $stable(dnl_min)
                             && $stable(inl_max) && $stable(inl_min));

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_zero && !start) |=> ref_zero);

   a_r8_dnl_order: assert property (@(posedge clk) disable iff (!rst_n)
      dnl_max >= dnl_min);

   a_r8_inl_order: assert property (@(posedge clk) disable iff (!rst_n)
      inl_max >= inl_min);
endmodule

bind hist_adc_analyzer hist_adc_analyzer_chk #(
   .CODE_W(CODE_W), .DNL_W(DNL_W), .INL_W(INL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .done(done), .ref_req(ref_req),
   .ref_idx(ref_idx), .ref_zero(ref_zero), .dnl_max(dnl_max),
   .dnl_min(dnl_min), .inl_max(inl_max), .inl_min(inl_min)
);

// File: tb/hist_adc_analyzer_bench.sv
`timescale 1ns/1ps
module hist_adc_analyzer_bench;
   localparam int CODE_W = 8;
   localparam int CNT_W  = 16;
   localparam int RLOG   = 10;
   localparam int FRAC_W = 8;
   localparam int NREC   = 2 ** RLOG;
   localparam int NB     = 2 ** CODE_W;
   localparam int DW     = CNT_W + FRAC_W + 2;
   localparam int IW     = DW + CODE_W;

   // scenario table: stimulus pattern, reference mode, expected error flag
   localparam int NSC = 4;
   localparam int SC_PAT [NSC] = '{0, 1, 2, 2};
   localparam int SC_REF [NSC] = '{0, 1, 0, 2};
   localparam int SC_ERR [NSC] = '{0, 0, 0, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic code_valid = 1'b0;
   logic [CODE_W-1:0] code = '0;
   logic ref_req;
   logic [CODE_W-1:0] ref_idx;
   logic [CNT_W-1:0] ref_cnt = '0;
   logic done, ref_zero;
   logic [CNT_W-1:0] h_low, h_high;
   logic signed [DW-1:0] dnl_max, dnl_min;
   logic signed [IW-1:0] inl_max, inl_min;

   int n_chk = 0;
   int n_fail = 0;
   int cur_ref = 0;
   int exp_idx = 1;
   int req_n = 0;
   int ord_bad = 0;

   longint e_h [NB];
   longint e_dmax, e_dmin, e_imax, e_imin;

   always #4 clk = ~clk;

   hist_adc_analyzer #(
      .CODE_W(CODE_W), .CNT_W(CNT_W), .RECORD_LOG2(RLOG), .FRAC_W(FRAC_W)
   ) u_hist_adc_analyzer (
      .clk(clk), .rst_n(rst_n), .start(start), .code_valid(code_valid),
      .code(code), .ref_req(ref_req), .ref_idx(ref_idx), .ref_cnt(ref_cnt),
      .done(done), .ref_zero(ref_zero), .h_low(h_low), .h_high(h_high),
      .dnl_max(dnl_max), .dnl_min(dnl_min), .inl_max(inl_max), .inl_min(inl_min)
   );

   function automatic int gen(int pat, int k);
      case (pat)
         0: return k % NB;
         1: return (k * k + 3 * k) % NB;
         default: begin
            if (k % 4 == 0) return 0;
            if (k % 4 == 1) return NB - 1;
            return (k * 37) % NB;
         end
      endcase
   endfunction

   function automatic int ref_of(int m, int i);
      case (m)
         0: return 4;
         1: return 2 + (i % 5);
         default: return (i == 100) ? 0 : 4;
      endcase
   endfunction

   // reference responder: answer registered one cycle after a request (R5)
   always @(posedge clk) begin
      if (start) begin
         exp_idx <= 1;
         req_n   <= 0;
         ord_bad <= 0;
      end else if (ref_req) begin
         ref_cnt <= CNT_W'(ref_of(cur_ref, int'(ref_idx)));
         if (int'(ref_idx) != exp_idx) ord_bad <= ord_bad + 1;
         exp_idx <= exp_idx + 1;
         req_n   <= req_n + 1;
      end
   end

   task automatic chk(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model(int pat, int rm);
      longint d, acc, q;
      for (int b = 0; b < NB; b++) e_h[b] = 0;
      for (int k = 0; k < NREC; k++) e_h[gen(pat, k)]++;
      acc = 0;
      e_dmax = 0; e_dmin = 0; e_imax = 0; e_imin = 0;
      for (int i = 1; i <= NB - 2; i++) begin
         if (ref_of(rm, i) == 0) d = 0;
         else begin
            q = (e_h[i] << FRAC_W) / ref_of(rm, i);
            d = q - (longint'(1) << FRAC_W);
         end
         acc += d;
         if (i == 1 || d > e_dmax) e_dmax = d;
         if (i == 1 || d < e_dmin) e_dmin = d;
         if (i == 1 || acc > e_imax) e_imax = acc;
         if (i == 1 || acc < e_imin) e_imin = acc;
      end
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_scn(int pat, int rm, int eerr);
      bit seen;
      cur_ref = rm;
      model(pat, rm);
      pulse_start();
      for (int k = 0; k < NREC; k++) begin
         if (k % 5 == 4) begin
            code_valid = 1'b0;   // R2: idle slot carrying code 0, must not count
            code = '0;
            @(negedge clk);
         end
         code_valid = 1'b1;
         code = CODE_W'(gen(pat, k));
         @(negedge clk);
      end
      for (int k = 0; k < 20; k++) begin   // R3: beyond the record
         code_valid = 1'b1;
         code = '1;
         @(negedge clk);
      end
      code_valid = 1'b0;
      seen = 0;
      for (int c = 0; c < 20000 && !seen; c++) begin
         if (done) seen = 1;
         else @(negedge clk);
      end
      chk("R10 done seen", longint'(seen), 1);
      chk("R6 R8 dnl_max", longint'(dnl_max), e_dmax);
      chk("R6 R8 dnl_min", longint'(dnl_min), e_dmin);
      chk("R7 R8 inl_max", longint'(inl_max), e_imax);
      chk("R7 R8 inl_min", longint'(inl_min), e_imin);
      chk("R2 R4 h_low", longint'(h_low), e_h[0]);
      chk("R3 R4 h_high", longint'(h_high), e_h[NB-1]);
      chk("R9 ref_zero", longint'(ref_zero), longint'(eerr));
      chk("R5 request count", longint'(req_n), NB - 2);
      chk("R5 request order", longint'(ord_bad), 0);
      @(negedge clk);
      chk("R10 done width", longint'(done), 0);
      repeat (6) @(negedge clk);
      chk("R10 dnl_max held", longint'(dnl_max), e_dmax);
      chk("R10 inl_min held", longint'(inl_min), e_imin);
      chk("R10 no request", longint'(ref_req), 0);
   endtask

   initial begin
      #1500000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 done", longint'(done), 0);
      chk("R1 ref_req", longint'(ref_req), 0);
      chk("R1 ref_zero", longint'(ref_zero), 0);
      chk("R1 dnl_max", longint'(dnl_max), 0);
      chk("R1 inl_min", longint'(inl_min), 0);
      chk("R1 h_low", longint'(h_low), 0);
      chk("R1 h_high", longint'(h_high), 0);

      for (int s = 0; s < NSC; s++) run_scn(SC_PAT[s], SC_REF[s], SC_ERR[s]);

      // R11: abort a run partway, then restart; stale counts and flag must go
      pulse_start();
      for (int k = 0; k < 50; k++) begin
         code_valid = 1'b1;
         code = '0;
         @(negedge clk);
      end
      code_valid = 1'b0;
      chk("R11 partial count", longint'(h_low), 50);
      run_scn(0, 0, 0);
      chk("R11 cleared h_low", longint'(h_low), NREC / NB);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule